// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a flash controller. Once the host has issued the last write of a program or erase command sequence, it gives this block one start pulse. The pulse carries the operation kind, the target address and the byte that was meant to be written. From then on the block reads the flash status byte over a simple request/acknowledge read bus. It decides whether the operation has finished and whether the result is good.

The status byte uses two flags. Bit 7 is the completion flag. During a program it reads as the complement of the written bit 7 and turns true when the program finishes. During an erase it reads 0 and becomes 1 at the end. Bit 5 is the overtime flag.

Bit 7 can settle before the rest of the byte does. For that reason, once completion is seen, the block always makes one more read and judges the result from that second byte. When the overtime flag shows up first, the block re-reads once before it declares a failure. A poll budget set by a parameter bounds the whole wait.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A start pulse in the idle state captures the operation kind, the address and the expected byte. Every read the block then issues carries that captured address on `bus_addr_o`.
- R2: A start pulse that arrives while an operation is being polled is ignored. The result, the addresses read and the number of reads all stay as if the pulse had not arrived, and no second operation follows.
- R3: A status byte means "complete" when its bit 7 equals bit 7 of the expected byte (program, `op_erase_i`=0) or equals 1 (erase, `op_erase_i`=1).
- R4: After a complete status byte, exactly one more read is made. The result is pass only if that byte equals the full expected byte for a program, or 8'hFF for an erase. The `expect_i` value is ignored for an erase.
- R5: A status byte that is not complete but has bit 5 set causes exactly one recheck read. If the recheck is complete, the confirming read of R4 follows. Otherwise the result is fail with no further reads.
- R6: When a status byte is complete, bit 5 of the same byte has no effect.
- R7: When MAX_POLLS polling reads in a row are neither complete nor flagged by bit 5, the result is fail after exactly MAX_POLLS reads.
- R8: `done_o` is high for exactly one cycle, the cycle after the acknowledge of the final read. In that cycle exactly one of `pass_o`/`fail_o` is high, and both keep their values until the next accepted start.
- R9: After reset, `bus_req_o`, `done_o`, `pass_o` and `fail_o` are low.
- R10: A read completes in a cycle where `bus_req_o` and `bus_ack_i` are both high. `bus_req_o` stays high with a steady address until it is acknowledged, and drops in the cycle after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start polling (one-cycle pulse) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| addr_i | input | ADDR_W | Address to poll |
| expect_i | input | DATA_W | Byte that was programmed |
| bus_req_o | output | 1 | Read request |
| bus_addr_o | output | ADDR_W | Read address |
| bus_ack_i | input | 1 | Read acknowledge, data valid |
| bus_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | Operation succeeded |
| fail_o | output | 1 | Operation failed |

## Verification
The assertions assume that the bus only acknowledges while a request is pending, and that the read data is valid in the acknowledge cycle. The bench responder keeps to this: it answers a pending request one cycle later and never acknowledges twice in a row. It serves a scripted sequence of status bytes, with the busy length, the position of the overtime flag and the quality of the confirming byte swept across both operation kinds. Extra start pulses are sent only while a poll is clearly still in flight, so they can never be taken for a new operation.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_RECHK = 2'd2,
        ST_CONF  = 2'd3
    } fp_state_e;
endpackage

// File: rtl/poll_status_decode.sv
module poll_status_decode #(
    parameter int DATA_W   = 8,
    parameter int FLAG_BIT = 7,
    parameter int TOUT_BIT = 5
) (
    input  logic              is_erase,
    input  logic              exp_flag,
    input  logic [DATA_W-1:0] rdata,
    output logic              complete,
    output logic              overtime
);
    logic want_flag;

    always_comb begin
        want_flag = is_erase ? 1'b1 : exp_flag;
        complete  = (rdata[FLAG_BIT] == want_flag);
        overtime  = rdata[TOUT_BIT];
    end
endmodule

// File: rtl/poll_budget_cnt.sv
module poll_budget_cnt #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);
    localparam logic [CNT_W-1:0] TOP_VAL  = CNT_W'(MAX_POLLS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != TOP_VAL)
            cnt_d = cnt_q + 1'b1;
        last = (cnt_q == LAST_VAL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP_VAL);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import fpoll_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef struct packed {
        fp_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic              erase;
        logic              done;
        logic              pass;
        logic              fail;
    } regs_t;

    regs_t r_d, r_q;
    logic  cnt_clr, cnt_inc, cnt_last;
    logic  stat_complete, stat_overtime;

    poll_status_decode #(.DATA_W(DATA_W)) u_dec (
        .is_erase (r_q.erase),
        .exp_flag (r_q.exp[7]),
        .rdata    (bus_rdata_i),
        .complete (stat_complete),
        .overtime (stat_overtime)
    );

    poll_budget_cnt #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_POLL;
                    r_d.addr  = addr_i;
                    r_d.erase = op_erase_i;
                    r_d.exp   = op_erase_i ? ERASED : expect_i;
                    r_d.pass  = 1'b0;
                    r_d.fail  = 1'b0;
                    cnt_clr   = 1'b1;
                end
            end
            ST_POLL: begin
                if (bus_ack_i) begin
                    cnt_inc = 1'b1;
                    if (stat_complete) begin
                        r_d.st = ST_CONF;
                    end else if (stat_overtime) begin
                        r_d.st = ST_RECHK;
                    end else if (cnt_last) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.fail = 1'b1;
                    end
                end
            end
            ST_RECHK: begin
                if (bus_ack_i) begin
                    if (stat_complete) begin
                        r_d.st = ST_CONF;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.fail = 1'b1;
                    end
                end
            end
            ST_CONF: begin
                if (bus_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pass = (bus_rdata_i == r_q.exp);
                    r_d.fail = (bus_rdata_i != r_q.exp);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.exp   <= '0;
            r_q.erase <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.pass  <= 1'b0;
            r_q.fail  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req_o  = (r_q.st != ST_IDLE);
    assign bus_addr_o = r_q.addr;
    assign done_o     = r_q.done;
    assign pass_o     = r_q.pass;
    assign fail_o     = r_q.fail;

    // R8
    done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_ack_i));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)));
    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);
    // R10
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_i |-> bus_req_o);
    // R8
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !bus_req_o && !$past(start_i)) |-> ($stable(pass_o) && $stable(fail_o)));
endmodule

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;
    localparam int AW  = 18;
    localparam int DW  = 8;
    localparam int MAX = 8;
    localparam int NONE = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] expect_i = '0;
    logic          bus_req_o;
    logic [AW-1:0] bus_addr_o;
    logic          bus_ack_i;
    logic [DW-1:0] bus_rdata_i;
    logic          done_o, pass_o, fail_o;

    int n_checks = 0;
    int n_fail   = 0;

    // scenario controls, written by the stimulus process while idle
    logic          sc_erase = 1'b0;
    logic [DW-1:0] sc_exp = '0;
    logic [AW-1:0] sc_addr = '0;
    int            sc_busy = 0;
    int            sc_t5 = NONE;
    logic          sc_good = 1'b1;
    logic          clr_idx = 1'b0;

    // responder state
    int rd_idx = 0;
    int addr_err = 0;

    always #10 clk = ~clk;

    flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAX)) u_dut (
        .clk, .rst_n, .start_i, .op_erase_i, .addr_i, .expect_i,
        .bus_req_o, .bus_addr_o, .bus_ack_i, .bus_rdata_i,
        .done_o, .pass_o, .fail_o
    );

    function automatic logic [DW-1:0] status_byte(int k);
        logic [DW-1:0] full;
        logic          fl;
        full = sc_erase ? 8'hFF : sc_exp;
        fl   = sc_erase ? 1'b1 : sc_exp[7];
        if (k < sc_busy)
            return {~fl, k[0], (k >= sc_t5), 5'b01010};
        else if (k == sc_busy)
            return {fl, 1'b1, 1'b1, 5'b10101};
        else
            return full ^ (sc_good ? 8'h00 : 8'h01);
    endfunction

    // bus responder: acknowledges one cycle after a pending request
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack_i   <= 1'b0;
            bus_rdata_i <= '0;
            rd_idx      <= 0;
        end else begin
            bus_ack_i <= bus_req_o && !bus_ack_i;
            if (bus_req_o && !bus_ack_i)
                bus_rdata_i <= status_byte(rd_idx);
            if (clr_idx)
                rd_idx <= 0;
            else if (bus_req_o && bus_ack_i) begin
                rd_idx <= rd_idx + 1;
                // R1 / R10: every completed read uses the captured address
                if (bus_addr_o != sc_addr) addr_err <= addr_err + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input bit erase, input int busy, input int t5, input bit good, input int id);
        bit exp_pass;
        int exp_reads;
        int waited;
        bit seen;
        bit extra;
        @(negedge clk);
        sc_erase = erase;
        sc_busy  = busy;
        sc_t5    = t5;
        sc_good  = good;
        sc_exp   = 8'(id * 37 + 8'h15);
        sc_addr  = AW'(18'h2_0000 + id);
        clr_idx  = 1'b1;
        start_i  = 1'b1;
        op_erase_i = erase;
        addr_i   = sc_addr;
        expect_i = sc_exp;
        @(negedge clk);
        start_i = 1'b0;
        clr_idx = 1'b0;
        // expected outcome from the requirements
        if (busy < MAX && busy <= t5) begin
            exp_pass = good; exp_reads = busy + 2;          // R3, R4, R6
        end else if (t5 < busy && t5 < MAX) begin            // R5
            if (busy == t5 + 1) begin exp_pass = good; exp_reads = t5 + 3; end
            else begin exp_pass = 1'b0; exp_reads = t5 + 2; end
        end else begin
            exp_pass = 1'b0; exp_reads = MAX;                 // R7
        end
        extra = (exp_reads >= 4);
        seen = 1'b0;
        waited = 0;
        while (!seen && waited < 400) begin
            if (extra && waited == 2) begin
                // R2: start pulse during polling, different address and kind
                start_i = 1'b1; op_erase_i = ~erase; addr_i = sc_addr ^ 18'h00F0;
                expect_i = ~sc_exp;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            waited++;
            if (done_o) seen = 1'b1;
        end
        start_i = 1'b0;
        check(seen, "R8 done strobe", int'(seen), 1);
        check(pass_o == exp_pass, erase ? "R4 erase pass" : "R4 program pass", int'(pass_o), int'(exp_pass));
        check(fail_o == !exp_pass, "R8 fail flag", int'(fail_o), int'(!exp_pass));
        check(rd_idx == exp_reads, t5 < busy ? "R5 read count" : "R7 read count", rd_idx, exp_reads);
        check(addr_err == 0, extra ? "R2 address" : "R1 address", addr_err, 0);
        @(negedge clk);
        check(!done_o, "R8 done single cycle", int'(done_o), 0);
        check(!bus_req_o, "R10 req dropped", int'(bus_req_o), 0);
        @(negedge clk);
        @(negedge clk);
        check(pass_o == exp_pass && fail_o == !exp_pass, "R8 verdict held", int'(pass_o), int'(exp_pass));
        if (extra) check(!bus_req_o && rd_idx == exp_reads, "R2 no second operation", rd_idx, exp_reads);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int id;
        id = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!bus_req_o && !done_o && !pass_o && !fail_o, "R9 reset outputs",
              int'({bus_req_o, done_o, pass_o, fail_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req_o && !done_o, "R9 idle after reset", int'(bus_req_o), 0);
        for (int op = 0; op < 2; op++)
            for (int b = 0; b <= MAX + 1; b++)
                for (int t = 0; t <= MAX + 2; t++)
                    for (int g = 0; g < 2; g++) begin
                        run(op[0], b, (t > MAX + 1) ? NONE : t, g[0], id);
                        id++;
                    end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule